// File: doc/BRIEF.md
# Receive Descriptor Chain DMA Engine

This block moves received packet words from a valid/ready stream into host memory. Software builds a chain of empty receive descriptors in shared memory, and the engine is started at the head of that chain. For each descriptor the engine reads three words in one burst. It then stores the packet payload into the buffer that the descriptor names, one single-word write per stream word. When the packet ends, the engine marks the descriptor complete by overwriting its first word with a status word. It then writes an interrupt vector into a circular receive queue, stores the next descriptor's address at a fixed pointer location, and moves on to that descriptor.

The stream side follows valid/ready rules. A word transfers on a clock edge where `s_valid` and `s_ready` are both high. The source must hold `s_data`, `s_last` and `s_abort` stable while `s_valid` is high and `s_ready` is low. `s_ready` is high only while the engine is waiting for a payload word and has no bus request open. It is therefore low during descriptor fetches, during each payload write, during status, vector and pointer writes, and while the engine is held.

The memory side uses a request/acknowledge handshake. `m_req` and its attributes stay stable until `m_ack` is high on a clock edge. A burst read returns its three words on `m_rvalid` in the cycles after its acknowledge. The configuration addresses must stay stable while the engine runs.

Top module: `rxdesc_dma`

## Requirements
- R1: When `cfg_start` is pulsed while the engine is idle, the first bus transaction is a burst read (`m_burst`=1, `m_we`=0) at `cfg_list_addr`. It returns three descriptor words.
- R2: The descriptor layout is as follows. Word 0 holds the hold flag in bit 31 and the buffer size in 32-bit words in bits [15:0]. Word 1 holds the buffer byte address. Word 2 holds the next descriptor byte address.
- R3: Each accepted payload word that fits the buffer is written as one single-word write (`m_burst`=0) at buffer address + 4*n, where n counts the words stored so far. Burst requests are only ever reads.
- R4: Payload words that arrive after the buffer is full are accepted and dropped with no bus write, and the overflow flag is set.
- R5: After the last payload write, descriptor word 0 is overwritten with the status word. Bit 31 is 1 (complete), bit 30 is overflow, bit 29 is `s_abort` as sampled with `s_last`, bits [15:0] are 4 times the stored word count, and all other bits are 0.
- R6: Each packet then writes exactly one vector at `cfg_queue_base` + 4*`q_wr_ptr`. Bits [31:28] are 4'h8, bit 27 is overflow, bit 26 is abort, bits [15:0] are the byte count, and all other bits are 0. `q_wr_ptr` then steps by one and wraps from QDEPTH-1 to 0.
- R7: After the vector, the next descriptor address is written to `cfg_ccb_addr`, and the next descriptor is fetched from that address.
- R8: The status write, the vector write and the pointer write happen in that order. Each one starts only after the previous one has been acknowledged.
- R9: `s_ready` is never high while `m_req` is high, and it is low while a descriptor is being fetched.
- R10: A fetched descriptor with the hold flag set makes the engine stop with `rx_held` high, `s_ready` low and no bus traffic. A `resume` pulse makes it fetch the same descriptor again.
- R11: Once `m_req` is raised, it stays high with `m_addr`, `m_we`, `m_burst` and `m_wdata` unchanged until `m_ack` is seen.
- R12: After reset, `m_req`, `s_ready` and `rx_held` are low and `q_wr_ptr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | Start pulse; only acted on while idle |
| cfg_list_addr | input | 32 | Byte address of the first descriptor |
| cfg_ccb_addr | input | 32 | Byte address where the current descriptor address is stored |
| cfg_queue_base | input | 32 | Byte address of receive vector queue slot 0 |
| resume | input | 1 | Restart pulse; only acted on while held |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word accepted when high with s_valid |
| s_data | input | 32 | Stream payload word |
| s_last | input | 1 | Marks the final word of a packet |
| s_abort | input | 1 | Packet aborted; sampled with s_last |
| m_req | output | 1 | Bus request |
| m_we | output | 1 | Request is a write |
| m_burst | output | 1 | Request is a three-word burst read |
| m_addr | output | 32 | Request byte address |
| m_wdata | output | 32 | Write data |
| m_ack | input | 1 | Request accepted/completed |
| m_rvalid | input | 1 | Read data beat valid |
| m_rdata | input | 32 | Read data beat |
| rx_held | output | 1 | Engine stopped on a held descriptor |
| q_wr_ptr | output | $clog2(QDEPTH) | Next receive queue slot |

## Verification
The first completion write is requested in the cycle after the acknowledge of the final payload write, or, for a dropped final word, in the cycle after that word is accepted. The vector and pointer writes then each follow the previous acknowledge by one cycle, and `q_wr_ptr` changes on the same edge that acknowledges the vector. The memory model logs every acknowledged transaction in order. After each packet, the bench waits at falling edges until the pointer write appears in the log and only then compares memory, log entries and `q_wr_ptr`, so no check depends on a guessed cycle count. Held-state checks sample `rx_held`, `s_ready` and the acknowledge count over a quiet window of many cycles, before and after a resume pulse.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 3;

  // descriptor word 0 fields
  localparam int HOLD_BIT = 31;
  localparam int SIZE_W   = 16;

  // status word fields
  localparam int ST_DONE_BIT = 31;
  localparam int ST_OVF_BIT  = 30;
  localparam int ST_ABT_BIT  = 29;

  // vector word fields
  localparam logic [3:0] VEC_TAG = 4'h8;
  localparam int VEC_OVF_BIT = 27;
  localparam int VEC_ABT_BIT = 26;

  typedef struct packed {
    logic              hold;
    logic [SIZE_W-1:0] size;
    logic [WORD_W-1:0] buf_addr;
    logic [WORD_W-1:0] next_addr;
  } rxd_desc_t;

  typedef enum logic [3:0] {
    S_IDLE, S_FREQ, S_FBEAT, S_HELD, S_RECV, S_DWR, S_STAT, S_VEC, S_CCB
  } rxd_state_e;

  function automatic logic [WORD_W-1:0] make_status(logic ovf, logic abt,
                                                   logic [SIZE_W-1:0] bytes);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ST_DONE_BIT] = 1'b1;
    w[ST_OVF_BIT]  = ovf;
    w[ST_ABT_BIT]  = abt;
    w[SIZE_W-1:0]  = bytes;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] make_vector(logic ovf, logic abt,
                                                   logic [SIZE_W-1:0] bytes);
    logic [WORD_W-1:0] w;
    w = '0;
    w[WORD_W-1 -: 4] = VEC_TAG;
    w[VEC_OVF_BIT]   = ovf;
    w[VEC_ABT_BIT]   = abt;
    w[SIZE_W-1:0]    = bytes;
    return w;
  endfunction

endpackage

// File: rtl/rxd_desc_fetch.sv
module rxd_desc_fetch
  import rxd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              beat,
  input  logic [WORD_W-1:0] beat_data,
  output logic              done,
  output rxd_desc_t         desc
);
  localparam int IDXW = $clog2(DESC_WORDS);

  logic [IDXW-1:0]   idx;
  logic [WORD_W-1:0] words [DESC_WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n)     idx <= '0;
    else if (start) idx <= '0;
    else if (beat)  idx <= idx + 1'b1;
  end

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                         words[g] <= '0;
      else if (beat && idx == IDXW'(g))   words[g] <= beat_data;
    end
  end

  assign done = beat && (idx == IDXW'(DESC_WORDS - 1));

  always_comb begin
    desc.hold      = words[0][HOLD_BIT];
    desc.size      = words[0][SIZE_W-1:0];
    desc.buf_addr  = words[1];
    desc.next_addr = words[2];
  end
endmodule

// File: rtl/rxd_fill_ctr.sv
module rxd_fill_ctr
  import rxd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              stored,
  input  logic              dropped,
  input  logic [SIZE_W-1:0] size,
  input  logic [WORD_W-1:0] base,
  output logic              room,
  output logic              ovf,
  output logic [SIZE_W-1:0] bytes,
  output logic [WORD_W-1:0] wr_addr
);
  localparam int PADW = WORD_W - SIZE_W - 2;

  logic [SIZE_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (stored)  count <= count + 1'b1;
      if (dropped) ovf   <= 1'b1;
    end
  end

  assign room    = count < size;
  assign bytes   = {count[SIZE_W-3:0], 2'b00};
  assign wr_addr = base + {{PADW{1'b0}}, count, 2'b00};
endmodule

// File: rtl/rxd_qptr.sv
module rxd_qptr #(
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

  if (POW2) begin : g_pow2
    always_ff @(posedge clk) begin
      if (!rst_n)   ptr <= '0;
      else if (adv) ptr <= ptr + 1'b1;
    end
  end else begin : g_mod
    always_ff @(posedge clk) begin
      if (!rst_n)   ptr <= '0;
      else if (adv) ptr <= (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/rxdesc_dma.sv
module rxdesc_dma
  import rxd_pkg::*;
#(
  parameter int QDEPTH = 8,
  localparam int QPW   = $clog2(QDEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start,
  input  logic [WORD_W-1:0] cfg_list_addr,
  input  logic [WORD_W-1:0] cfg_ccb_addr,
  input  logic [WORD_W-1:0] cfg_queue_base,
  input  logic              resume,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_last,
  input  logic              s_abort,
  output logic              m_req,
  output logic              m_we,
  output logic              m_burst,
  output logic [WORD_W-1:0] m_addr,
  output logic [WORD_W-1:0] m_wdata,
  input  logic              m_ack,
  input  logic              m_rvalid,
  input  logic [WORD_W-1:0] m_rdata,
  output logic              rx_held,
  output logic [QPW-1:0]    q_wr_ptr
);
  rxd_state_e state, nxt;

  logic [WORD_W-1:0] cur_addr;
  logic [WORD_W-1:0] data_q;
  logic              last_q;
  logic              abt_q;

  rxd_desc_t         desc;
  logic              fetch_start, fetch_beat, fetch_done;
  logic              room, ovf, accept, stored, dropped;
  logic [SIZE_W-1:0] bytes;
  logic [WORD_W-1:0] wr_addr;
  logic              q_adv;

  assign fetch_start = (state == S_IDLE && cfg_start) ||
                       (state == S_HELD && resume) ||
                       (state == S_CCB && m_ack);
  assign fetch_beat  = (state == S_FBEAT) && m_rvalid;
  assign accept      = (state == S_RECV) && s_valid;
  assign stored      = (state == S_DWR) && m_ack;
  assign dropped     = accept && !room;
  assign q_adv       = (state == S_VEC) && m_ack;

  rxd_desc_fetch u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (fetch_start),
    .beat      (fetch_beat),
    .beat_data (m_rdata),
    .done      (fetch_done),
    .desc      (desc)
  );

  rxd_fill_ctr u_fill (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (fetch_done),
    .stored  (stored),
    .dropped (dropped),
    .size    (desc.size),
    .base    (desc.buf_addr),
    .room    (room),
    .ovf     (ovf),
    .bytes   (bytes),
    .wr_addr (wr_addr)
  );

  rxd_qptr #(.DEPTH(QDEPTH)) u_qptr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (q_adv),
    .ptr   (q_wr_ptr)
  );

  // next-state logic
  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:  if (cfg_start)  nxt = S_FREQ;
      S_FREQ:  if (m_ack)      nxt = S_FBEAT;
      S_FBEAT: if (fetch_done) nxt = desc.hold ? S_HELD : S_RECV;
      S_HELD:  if (resume)     nxt = S_FREQ;
      S_RECV: begin
        if (s_valid) begin
          if (room)        nxt = S_DWR;
          else if (s_last) nxt = S_STAT;
        end
      end
      S_DWR:   if (m_ack)      nxt = last_q ? S_STAT : S_RECV;
      S_STAT:  if (m_ack)      nxt = S_VEC;
      S_VEC:   if (m_ack)      nxt = S_CCB;
      S_CCB:   if (m_ack)      nxt = S_FREQ;
      default:                 nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  // descriptor pointer and captured payload word
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      data_q   <= '0;
      last_q   <= 1'b0;
      abt_q    <= 1'b0;
    end else begin
      if (state == S_IDLE && cfg_start) cur_addr <= cfg_list_addr;
      else if (state == S_CCB && m_ack) cur_addr <= desc.next_addr;
      if (fetch_done) abt_q <= 1'b0;
      if (accept) begin
        data_q <= s_data;
        last_q <= s_last;
        if (s_last) abt_q <= s_abort;
      end
    end
  end

  // bus request mux
  always_comb begin
    m_req   = 1'b0;
    m_we    = 1'b0;
    m_burst = 1'b0;
    m_addr  = '0;
    m_wdata = '0;
    unique case (state)
      S_FREQ: begin
        m_req   = 1'b1;
        m_burst = 1'b1;
        m_addr  = cur_addr;
      end
      S_DWR: begin
        m_req   = 1'b1;
        m_we    = 1'b1;
        m_addr  = wr_addr;
        m_wdata = data_q;
      end
      S_STAT: begin
        m_req   = 1'b1;
        m_we    = 1'b1;
        m_addr  = cur_addr;
        m_wdata = make_status(ovf, abt_q, bytes);
      end
      S_VEC: begin
        m_req   = 1'b1;
        m_we    = 1'b1;
        m_addr  = cfg_queue_base + {{(WORD_W-QPW-2){1'b0}}, q_wr_ptr, 2'b00};
        m_wdata = make_vector(ovf, abt_q, bytes);
      end
      S_CCB: begin
        m_req   = 1'b1;
        m_we    = 1'b1;
        m_addr  = cfg_ccb_addr;
        m_wdata = desc.next_addr;
      end
      default: ;
    endcase
  end

  assign s_ready = (state == S_RECV);
  assign rx_held = (state == S_HELD);
endmodule

// File: rtl/rxdesc_dma_chk.sv
module rxdesc_dma_chk #(
  parameter int QDEPTH = 8,
  localparam int QPW   = $clog2(QDEPTH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           s_ready,
  input logic           m_req,
  input logic           m_we,
  input logic           m_burst,
  input logic [31:0]    m_addr,
  input logic [31:0]    m_wdata,
  input logic           m_ack,
  input logic           rx_held,
  input logic [QPW-1:0] q_wr_ptr
);
  p_ready_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !m_req);

  p_req_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we) &&
                           $stable(m_burst) && $stable(m_wdata)));

  p_burst_is_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_burst) |-> !m_we);

  p_held_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_held |-> (!s_ready && !m_req));

  p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_wr_ptr) < QDEPTH);

  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_wr_ptr != $past(q_wr_ptr)) |->
      (int'(q_wr_ptr) == (int'($past(q_wr_ptr)) + 1) % QDEPTH));
endmodule

bind rxdesc_dma rxdesc_dma_chk #(.QDEPTH(QDEPTH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_ready  (s_ready),
  .m_req    (m_req),
  .m_we     (m_we),
  .m_burst  (m_burst),
  .m_addr   (m_addr),
  .m_wdata  (m_wdata),
  .m_ack    (m_ack),
  .rx_held  (rx_held),
  .q_wr_ptr (q_wr_ptr)
);

// File: tb/rxdesc_dma_tb_top.sv
module rxdesc_dma_tb_top;
  localparam int QD = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_start = 0, resume = 0;
  logic [31:0] cfg_list_addr = 32'h000, cfg_ccb_addr = 32'h1F0, cfg_queue_base = 32'h100;
  logic        s_valid = 0, s_ready, s_last = 0, s_abort = 0;
  logic [31:0] s_data = 0;
  logic        m_req, m_we, m_burst, m_ack, m_rvalid;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic        rx_held;
  logic [1:0]  q_wr_ptr;

  always #5 clk = ~clk;

  rxdesc_dma #(.QDEPTH(QD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_list_addr(cfg_list_addr),
    .cfg_ccb_addr(cfg_ccb_addr), .cfg_queue_base(cfg_queue_base), .resume(resume),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .s_abort(s_abort), .m_req(m_req), .m_we(m_we), .m_burst(m_burst),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_ack(m_ack), .m_rvalid(m_rvalid),
    .m_rdata(m_rdata), .rx_held(rx_held), .q_wr_ptr(q_wr_ptr)
  );

  // memory model with transaction log
  logic [31:0] mem [256];
  logic        poke_en = 0;
  logic [31:0] poke_addr = 0, poke_data = 0;
  logic [31:0] log_addr [64];
  logic        log_we [64];
  logic        log_burst [64];
  int          log_n = 0, ack_total = 0, ccb_cnt = 0, rbeats = 0, ready_req_clash = 0;
  logic [31:0] raddr = 0;

  always @(posedge clk) begin
    if (poke_en) mem[poke_addr[9:2]] <= poke_data;
    if (!rst_n) begin
      m_ack <= 0; m_rvalid <= 0; m_rdata <= 0; rbeats <= 0;
    end else begin
      m_rvalid <= 0;
      if (m_req && !m_ack) begin
        m_ack <= 1;
        ack_total <= ack_total + 1;
        if (log_n < 64) begin
          log_addr[log_n] <= m_addr; log_we[log_n] <= m_we; log_burst[log_n] <= m_burst;
        end
        log_n <= log_n + 1;
        if (m_we) begin
          mem[m_addr[9:2]] <= m_wdata;
          if (m_addr == 32'h1F0) ccb_cnt <= ccb_cnt + 1;
        end else if (m_burst) begin
          rbeats <= 3; raddr <= m_addr;
        end
      end else m_ack <= 0;
      if (rbeats > 0) begin
        m_rvalid <= 1; m_rdata <= mem[raddr[9:2]];
        raddr <= raddr + 4; rbeats <= rbeats - 1;
      end
    end
  end

  always @(negedge clk) if (rst_n && s_ready && m_req) ready_req_clash++;

  int n_chk = 0, n_bad = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(logic [31:0] a, logic [31:0] d);
    @(negedge clk); poke_en = 1; poke_addr = a; poke_data = d;
    @(negedge clk); poke_en = 0;
  endtask

  task automatic send_word(logic [31:0] d, logic last, logic abt);
    @(negedge clk);
    s_valid = 1; s_data = d; s_last = last; s_abort = abt;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 0; s_last = 0; s_abort = 0;
  endtask

  task automatic wait_ccb(int k);
    int t = 0;
    while (ccb_cnt < k && t < 3000) begin @(negedge clk); t++; end
    chk("R7 pointer write seen", ccb_cnt, k);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1;
    @(negedge clk); sig = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // R12: reset values
  task automatic t_reset_state();
    chk("R12 m_req", m_req, 0);
    chk("R12 s_ready", s_ready, 0);
    chk("R12 rx_held", rx_held, 0);
    chk("R12 q_wr_ptr", q_wr_ptr, 0);
  endtask

  // R1 R3 R5 R6 R7 R8 R9: normal packet of 3 words into a 4-word buffer
  task automatic t_first_packet();
    pulse(cfg_start);
    chk("R9 s_ready low during fetch", s_ready, 0);
    for (int i = 0; i < 3; i++) send_word(32'h1111_0000 + i, i == 2, 0);
    wait_ccb(1);
    chk("R1 first txn addr", log_addr[0], 32'h000);
    chk("R1 first txn burst read", {log_we[0], log_burst[0]}, 2'b01);
    for (int i = 0; i < 3; i++) begin
      chk("R3 payload word", mem[128 + i], 32'h1111_0000 + i);
      chk("R3 payload addr", log_addr[1 + i], 32'h200 + 4 * i);
      chk("R3 single word write", {log_we[1 + i], log_burst[1 + i]}, 2'b10);
    end
    chk("R8 status first", log_addr[4], 32'h000);
    chk("R8 vector second", log_addr[5], 32'h100);
    chk("R8 pointer third", log_addr[6], 32'h1F0);
    chk("R5 status word", mem[0], 32'h8000_000C);
    chk("R6 vector word", mem[64], 32'h8000_000C);
    chk("R7 pointer value", mem[124], 32'h010);
    chk("R6 q_wr_ptr", q_wr_ptr, 1);
    chk("R9 ready/request clash", ready_req_clash, 0);
  endtask

  // R2 R4: 5 words into a 2-word buffer
  task automatic t_overflow();
    for (int i = 0; i < 5; i++) send_word(32'h2222_0000 + i, i == 4, 0);
    wait_ccb(2);
    chk("R7 next fetch addr", log_addr[7], 32'h010);
    chk("R7 next fetch burst", {log_we[7], log_burst[7]}, 2'b01);
    chk("R4 stored word 0", mem[144], 32'h2222_0000);
    chk("R2 buffer base from word 1", log_addr[8], 32'h240);
    chk("R4 stored word 1", mem[145], 32'h2222_0001);
    chk("R4 past buffer untouched", mem[146], 32'hDEAD_BEEF);
    chk("R4 no write for dropped words", log_n, 13);
    chk("R5 overflow status", mem[4], 32'hC000_0008);
    chk("R6 overflow vector", mem[65], 32'h8800_0008);
    chk("R6 q_wr_ptr", q_wr_ptr, 2);
  endtask

  // R5 R6: aborted one-word packet
  task automatic t_abort();
    send_word(32'h3333_0000, 1, 1);
    wait_ccb(3);
    chk("R3 abort payload kept", mem[160], 32'h3333_0000);
    chk("R5 abort status", mem[8], 32'hA000_0004);
    chk("R6 abort vector", mem[66], 32'h8400_0004);
    chk("R6 q_wr_ptr", q_wr_ptr, 3);
  endtask

  // R10: held descriptor, resume while still held, then released
  task automatic t_hold();
    int snap;
    repeat (20) @(negedge clk);
    chk("R10 held", rx_held, 1);
    snap = ack_total;
    s_valid = 1; s_data = 32'hBAD0_BAD0; s_last = 1;
    repeat (10) @(negedge clk);
    chk("R10 no ready while held", s_ready, 0);
    chk("R10 no traffic while held", ack_total, snap);
    chk("R10 buffer untouched", mem[176], 32'h0);
    s_valid = 0; s_last = 0;
    pulse(resume);
    repeat (20) @(negedge clk);
    chk("R10 resume refetch count", ack_total, snap + 1);
    chk("R10 still held", rx_held, 1);
    poke(32'h030, 32'h0000_0004);
    pulse(resume);
    send_word(32'h4444_0000, 0, 0);
    send_word(32'h4444_0001, 1, 0);
    wait_ccb(4);
    chk("R10 released payload", mem[177], 32'h4444_0001);
    chk("R5 status after hold", mem[12], 32'h8000_0008);
    chk("R6 vector slot 3", mem[67], 32'h8000_0008);
    chk("R6 q_wr_ptr wrap", q_wr_ptr, 0);
  endtask

  // R6: vector after wrap lands in slot 0
  task automatic t_wrap();
    send_word(32'h5555_0000, 1, 0);
    wait_ccb(5);
    chk("R6 slot 0 rewritten", mem[64], 32'h8000_0004);
    chk("R6 q_wr_ptr after wrap", q_wr_ptr, 1);
    chk("R7 pointer value", mem[124], 32'h050);
    chk("R9 ready/request clash", ready_req_clash, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    poke(32'h000, 32'h0000_0004); poke(32'h004, 32'h200); poke(32'h008, 32'h010);
    poke(32'h010, 32'h0000_0002); poke(32'h014, 32'h240); poke(32'h018, 32'h020);
    poke(32'h020, 32'h0000_0004); poke(32'h024, 32'h280); poke(32'h028, 32'h030);
    poke(32'h030, 32'h8000_0004); poke(32'h034, 32'h2C0); poke(32'h038, 32'h040);
    poke(32'h040, 32'h0000_0004); poke(32'h044, 32'h300); poke(32'h048, 32'h050);
    poke(32'h050, 32'h8000_0004); poke(32'h054, 32'h340); poke(32'h058, 32'h060);
    poke(32'h248, 32'hDEAD_BEEF);
    poke(32'h2C0, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_first_packet();
    t_overflow();
    t_abort();
    t_hold();
    t_wrap();
    summary();
    $finish;
  end
endmodule